// File: doc/BRIEF.md
# Modbus Slave Command Executor

This block executes Modbus requests that a framing layer has already received and checked. The request arrives as decoded fields: slave address, function code, start address, and a count or data value, together with a one-cycle valid strobe. The block holds a small set of single-bit controller flags and a bank of 16-bit words. It reads or updates them and, one clock later, presents the response fields for the framing layer to send back.

Four functions are executed. Function 02 reads flags, 05 writes one flag, 03 reads words and 06 writes one word. Any other function code, a malformed flag-write value or a count out of range produces an exception response and leaves the state alone. A request addressed to another slave gets no response at all.

The flag area has five flags starting at bit address 0812H. In address order they are the decimal-point select (1 means one decimal place), auto-tune enable, run/stop (1 means run), program stop, and program temporary stop. The word bank begins at 1000H.

Top module: `mbx_exec`

## Requirements
- R1: A request with `req_slave` equal to the parameter SLAVE_ID (default 01H) raises `rsp_valid` for exactly one cycle, in the cycle after the strobe, with `rsp_slave` equal to SLAVE_ID. A request for any other address raises no response and changes no flag or word.
- R2: After reset, `rsp_valid` is 0. The flags at 0812H..0816H read 0,0,1,0,0, so only the run/stop flag at 0814H is set, and every word reads 0000H.
- R3: Function 02 with a count of 1 to 8 responds with `rsp_bytes` = 1. The data byte sits in `rsp_data[63:56]` and holds the flag at start+j in bit j (LSB first). Bits beyond the count, and addresses outside 0812H..0816H, read 0. The rest of `rsp_data` is 0.
- R4: Function 05 with value FF00H sets the addressed flag and value 0000H clears it. The response echoes the start address in `rsp_echo_addr` and the value in `rsp_echo_val`. Any other value gives an exception response and leaves all flags unchanged.
- R5: Function 03 with a count of 1 to 4 responds with `rsp_bytes` = 2 x count. The word at start+k sits in `rsp_data[63-16k -: 16]`, so the first word is in the top bits and each word's high byte comes first. Slots beyond the count, and addresses outside 1000H..1007H, read 0.
- R6: Function 06 stores the value in the addressed word of 1000H..1007H and echoes the address and value unchanged. A write outside that range changes nothing but is still echoed.
- R7: Any function code other than 02, 03, 05 or 06 gives an exception response. It sets `rsp_exc` = 1 and `rsp_func` = code OR 80H, with zero bytes, zero data and zero echo fields, and it changes no state.
- R8: Function 02 with a count of 0 or above 8, or function 03 with a count of 0 or above 4, gives an exception response as in R7.
- R9: A successful response has `rsp_exc` = 0 and `rsp_func` equal to the request's function code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | One-cycle strobe for a checked request |
| req_slave | input | 8 | Slave address of the request |
| req_func | input | 8 | Function code |
| req_start | input | 16 | Start (bit or word) address |
| req_value | input | 16 | Count for reads, data for writes |
| rsp_valid | output | 1 | Response fields valid this cycle |
| rsp_exc | output | 1 | Exception response |
| rsp_slave | output | 8 | Slave address to answer with |
| rsp_func | output | 8 | Function code, top bit set on exception |
| rsp_echo_addr | output | 16 | Echoed address for writes |
| rsp_echo_val | output | 16 | Echoed value for writes |
| rsp_bytes | output | 8 | Byte count for reads |
| rsp_data | output | 64 | Read data, first byte in the top bits |

## Verification
The hardest cases to show are the ones where nothing should happen. A foreign slave address, an unsupported function code or a bad flag-write value must leave every flag and word as it was, yet the block has no output that shows state unless a read is issued. The bench therefore sweeps every foreign address and every unsupported code while carrying write-shaped payloads that would flip a known flag or word. After each sweep it reads back the whole flag area and word bank. Read windows that straddle both edges of each map are swept for every start and count, so that out-of-range padding is exercised.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam logic [7:0]  FC_RD_BITS  = 8'h02;
    localparam logic [7:0]  FC_RD_WORDS = 8'h03;
    localparam logic [7:0]  FC_WR_BIT   = 8'h05;
    localparam logic [7:0]  FC_WR_WORD  = 8'h06;
    localparam logic [7:0]  EXC_MARK    = 8'h80;
    localparam logic [15:0] BIT_SET_VAL = 16'hFF00;
    localparam logic [15:0] BIT_CLR_VAL = 16'h0000;

    typedef enum logic [2:0] {
        OP_NONE,
        OP_RD_BITS,
        OP_WR_BIT,
        OP_RD_WORDS,
        OP_WR_WORD,
        OP_REJECT
    } op_e;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
    import mbx_pkg::*;
#(
    parameter logic [7:0] SLAVE_ID  = 8'h01,
    parameter int         MAX_BITS  = 8,
    parameter int         MAX_WORDS = 4
) (
    input  logic        req_valid,
    input  logic [7:0]  req_slave,
    input  logic [7:0]  req_func,
    input  logic [15:0] req_value,
    output op_e         op
);
    logic bits_cnt_ok;
    logic words_cnt_ok;
    logic coil_ok;

    always_comb begin
        bits_cnt_ok  = (req_value != 16'd0) && (req_value <= 16'(MAX_BITS));
        words_cnt_ok = (req_value != 16'd0) && (req_value <= 16'(MAX_WORDS));
        coil_ok      = (req_value == BIT_SET_VAL) || (req_value == BIT_CLR_VAL);
        op           = OP_NONE;
        if (req_valid && (req_slave == SLAVE_ID)) begin
            case (req_func)
                FC_RD_BITS:  op = bits_cnt_ok  ? OP_RD_BITS  : OP_REJECT;
                FC_RD_WORDS: op = words_cnt_ok ? OP_RD_WORDS : OP_REJECT;
                FC_WR_BIT:   op = coil_ok      ? OP_WR_BIT   : OP_REJECT;
                FC_WR_WORD:  op = OP_WR_WORD;
                default:     op = OP_REJECT;
            endcase
        end
    end
endmodule

// File: rtl/mbx_flags.sv
module mbx_flags #(
    parameter int                   NUM_FLAGS = 5,
    parameter logic [15:0]          BASE      = 16'h0812,
    parameter logic [NUM_FLAGS-1:0] RST_VAL   = 5'b00100,
    parameter int                   RD_SPAN   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [15:0]          wr_addr,
    input  logic                 wr_bit,
    input  logic [15:0]          rd_start,
    input  logic [15:0]          rd_count,
    output logic [RD_SPAN-1:0]   rd_bits,
    output logic [NUM_FLAGS-1:0] flags_o
);
    localparam logic [16:0] BASE_X = {1'b0, BASE};

    typedef struct packed {
        logic [NUM_FLAGS-1:0] flags;
    } flag_st_t;

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_FLAGS; i++) begin
                if ({1'b0, wr_addr} == BASE_X + 17'(i)) begin
                    st_d.flags[i] = wr_bit;
                end
            end
        end
    end

    always_comb begin
        for (int j = 0; j < RD_SPAN; j++) begin
            rd_bits[j] = 1'b0;
            for (int i = 0; i < NUM_FLAGS; i++) begin
                if (({1'b0, rd_start} + 17'(j) == BASE_X + 17'(i)) &&
                    (16'(j) < rd_count)) begin
                    rd_bits[j] = st_q.flags[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flags <= RST_VAL;
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;
endmodule

// File: rtl/mbx_words.sv
module mbx_words #(
    parameter int          NUM_WORDS = 8,
    parameter logic [15:0] BASE      = 16'h1000,
    parameter int          MAX_RD    = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [15:0]          wr_addr,
    input  logic [15:0]          wr_data,
    input  logic [15:0]          rd_start,
    input  logic [15:0]          rd_count,
    output logic [MAX_RD*16-1:0] rd_data
);
    localparam logic [16:0] BASE_X = {1'b0, BASE};

    typedef struct packed {
        logic [NUM_WORDS-1:0][15:0] w;
    } word_st_t;

    word_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if ({1'b0, wr_addr} == BASE_X + 17'(i)) begin
                    st_d.w[i] = wr_data;
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < MAX_RD; k++) begin
            for (int i = 0; i < NUM_WORDS; i++) begin
                if (({1'b0, rd_start} + 17'(k) == BASE_X + 17'(i)) &&
                    (16'(k) < rd_count)) begin
                    rd_data[(MAX_RD-k)*16-1 -: 16] = st_q.w[i];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/mbx_exec.sv
module mbx_exec
    import mbx_pkg::*;
#(
    parameter logic [7:0]           SLAVE_ID     = 8'h01,
    parameter int                   NUM_FLAGS    = 5,
    parameter logic [15:0]          FLAG_BASE    = 16'h0812,
    parameter logic [NUM_FLAGS-1:0] FLAG_RST     = 5'b00100,
    parameter int                   NUM_WORDS    = 8,
    parameter logic [15:0]          WORD_BASE    = 16'h1000,
    parameter int                   MAX_RD_WORDS = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       req_valid,
    input  logic [7:0]                 req_slave,
    input  logic [7:0]                 req_func,
    input  logic [15:0]                req_start,
    input  logic [15:0]                req_value,
    output logic                       rsp_valid,
    output logic                       rsp_exc,
    output logic [7:0]                 rsp_slave,
    output logic [7:0]                 rsp_func,
    output logic [15:0]                rsp_echo_addr,
    output logic [15:0]                rsp_echo_val,
    output logic [7:0]                 rsp_bytes,
    output logic [MAX_RD_WORDS*16-1:0] rsp_data
);
    localparam int DW      = MAX_RD_WORDS * 16;
    localparam int RD_BITS = 8;

    typedef struct packed {
        logic           valid;
        logic           exc;
        logic [7:0]     slave;
        logic [7:0]     func;
        logic [15:0]    eaddr;
        logic [15:0]    eval;
        logic [7:0]     bytes;
        logic [DW-1:0]  data;
    } rsp_t;

    op_e                  op;
    logic [RD_BITS-1:0]   bit_rd;
    logic [DW-1:0]        word_rd;
    logic [NUM_FLAGS-1:0] flag_vec;
    rsp_t                 r_d, r_q;

    mbx_decode #(
        .SLAVE_ID  (SLAVE_ID),
        .MAX_BITS  (RD_BITS),
        .MAX_WORDS (MAX_RD_WORDS)
    ) u_decode (
        .req_valid (req_valid),
        .req_slave (req_slave),
        .req_func  (req_func),
        .req_value (req_value),
        .op        (op)
    );

    mbx_flags #(
        .NUM_FLAGS (NUM_FLAGS),
        .BASE      (FLAG_BASE),
        .RST_VAL   (FLAG_RST),
        .RD_SPAN   (RD_BITS)
    ) u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (op == OP_WR_BIT),
        .wr_addr  (req_start),
        .wr_bit   (req_value[15]),
        .rd_start (req_start),
        .rd_count (req_value),
        .rd_bits  (bit_rd),
        .flags_o  (flag_vec)
    );

    mbx_words #(
        .NUM_WORDS (NUM_WORDS),
        .BASE      (WORD_BASE),
        .MAX_RD    (MAX_RD_WORDS)
    ) u_words (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (op == OP_WR_WORD),
        .wr_addr  (req_start),
        .wr_data  (req_value),
        .rd_start (req_start),
        .rd_count (req_value),
        .rd_data  (word_rd)
    );

    always_comb begin
        r_d = '0;
        if (op != OP_NONE) begin
            r_d.valid = 1'b1;
            r_d.slave = SLAVE_ID;
            r_d.func  = req_func;
        end
        case (op)
            OP_RD_BITS: begin
                r_d.bytes               = 8'd1;
                r_d.data[DW-1 -: RD_BITS] = bit_rd;
            end
            OP_RD_WORDS: begin
                r_d.bytes = {req_value[6:0], 1'b0};
                r_d.data  = word_rd;
            end
            OP_WR_BIT, OP_WR_WORD: begin
                r_d.eaddr = req_start;
                r_d.eval  = req_value;
            end
            OP_REJECT: begin
                r_d.exc  = 1'b1;
                r_d.func = req_func | EXC_MARK;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign rsp_valid     = r_q.valid;
    assign rsp_exc       = r_q.exc;
    assign rsp_slave     = r_q.slave;
    assign rsp_func      = r_q.func;
    assign rsp_echo_addr = r_q.eaddr;
    assign rsp_echo_val  = r_q.eval;
    assign rsp_bytes     = r_q.bytes;
    assign rsp_data      = r_q.data;
endmodule

// File: rtl/mbx_exec_chk.sv
module mbx_exec_chk #(
    parameter logic [7:0] SLAVE_ID  = 8'h01,
    parameter int         NUM_FLAGS = 5
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 req_valid,
    input logic [7:0]           req_slave,
    input logic [15:0]          req_start,
    input logic [15:0]          req_value,
    input logic                 rsp_valid,
    input logic                 rsp_exc,
    input logic [7:0]           rsp_func,
    input logic [15:0]          rsp_echo_addr,
    input logic [15:0]          rsp_echo_val,
    input logic [7:0]           rsp_bytes,
    input logic [NUM_FLAGS-1:0] flags
);
    AST_FOREIGN_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_slave != SLAVE_ID) |=> !rsp_valid); // R1

    AST_RSP_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($past(req_valid) && $past(req_slave) == SLAVE_ID)); // R1

    AST_EXC_MARKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc) |-> (rsp_func[7] && rsp_bytes == 8'd0)); // R7

    AST_EXC_NO_FLAG_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_exc) |-> $stable(flags)); // R4

    AST_BITS_ONE_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_exc && rsp_func == 8'h02) |-> (rsp_bytes == 8'd1)); // R3

    AST_WORD_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_exc && rsp_func == 8'h03) |->
        (rsp_bytes == {$past(req_value[6:0]), 1'b0})); // R5

    AST_WORD_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_exc && rsp_func == 8'h06) |->
        (rsp_echo_val == $past(req_value) && rsp_echo_addr == $past(req_start))); // R6
endmodule

bind mbx_exec mbx_exec_chk #(
    .SLAVE_ID  (SLAVE_ID),
    .NUM_FLAGS (NUM_FLAGS)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_slave     (req_slave),
    .req_start     (req_start),
    .req_value     (req_value),
    .rsp_valid     (rsp_valid),
    .rsp_exc       (rsp_exc),
    .rsp_func      (rsp_func),
    .rsp_echo_addr (rsp_echo_addr),
    .rsp_echo_val  (rsp_echo_val),
    .rsp_bytes     (rsp_bytes),
    .flags         (flag_vec)
);

// File: tb/test_mbx_exec.sv
`timescale 1ns/1ps
module test_mbx_exec;
    localparam logic [7:0] SID = 8'h01;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic [7:0]  req_slave, req_func;
    logic [15:0] req_start, req_value;
    logic        rsp_valid, rsp_exc;
    logic [7:0]  rsp_slave, rsp_func, rsp_bytes;
    logic [15:0] rsp_echo_addr, rsp_echo_val;
    logic [63:0] rsp_data;

    int checks = 0;
    int errors = 0;
    bit          fm [5];
    logic [15:0] wm [8];

    always #2 clk = ~clk;

    mbx_exec i_mbx_exec (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_slave(req_slave),
        .req_func(req_func), .req_start(req_start), .req_value(req_value),
        .rsp_valid(rsp_valid), .rsp_exc(rsp_exc), .rsp_slave(rsp_slave),
        .rsp_func(rsp_func), .rsp_echo_addr(rsp_echo_addr), .rsp_echo_val(rsp_echo_val),
        .rsp_bytes(rsp_bytes), .rsp_data(rsp_data)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] s, input logic [7:0] f, input logic [15:0] a, input logic [15:0] v);
        @(negedge clk);
        req_valid = 1'b1; req_slave = s; req_func = f; req_start = a; req_value = v;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    function automatic logic [7:0] exp_bits(input logic [15:0] st, input int cnt);
        logic [7:0] r = '0;
        for (int j = 0; j < 8; j++) begin
            int a = int'(st) + j;
            if (j < cnt && a >= 'h812 && a < 'h817) r[j] = fm[a - 'h812];
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_words(input logic [15:0] st, input int cnt);
        logic [63:0] r = '0;
        for (int k = 0; k < 4; k++) begin
            int a = int'(st) + k;
            if (k < cnt && a >= 'h1000 && a < 'h1008) r[(4-k)*16-1 -: 16] = wm[a - 'h1000];
        end
        return r;
    endfunction

    task automatic rd_bits(input logic [15:0] st, input int cnt, input string tag);
        logic [63:0] e;
        send(SID, 8'h02, st, 16'(cnt));
        e = {exp_bits(st, cnt), 56'h0};
        chk(rsp_valid && !rsp_exc && rsp_func == 8'h02 && rsp_slave == SID && rsp_bytes == 8'd1,
            {tag, " read-bits header"}, {rsp_valid, rsp_exc, rsp_func, rsp_bytes}, {2'b10, 8'h02, 8'h01});
        chk(rsp_data == e, {tag, " read-bits data"}, rsp_data, e);
    endtask

    task automatic rd_words(input logic [15:0] st, input int cnt, input string tag);
        logic [63:0] e;
        send(SID, 8'h03, st, 16'(cnt));
        e = exp_words(st, cnt);
        chk(rsp_valid && !rsp_exc && rsp_func == 8'h03 && rsp_bytes == 8'(2*cnt),
            {tag, " read-words header"}, {rsp_valid, rsp_exc, rsp_func, rsp_bytes}, {2'b10, 8'h03, 8'(2*cnt)});
        chk(rsp_data == e, {tag, " read-words data"}, rsp_data, e);
    endtask

    task automatic expect_exc(input logic [7:0] f, input string tag);
        chk(rsp_valid && rsp_exc && rsp_func == (f | 8'h80) && rsp_bytes == 0 && rsp_data == 0
            && rsp_echo_addr == 0 && rsp_echo_val == 0,
            tag, {rsp_valid, rsp_exc, rsp_func}, {2'b11, f | 8'h80});
    endtask

    task automatic wr_bit(input int idx, input bit v);
        logic [15:0] val = v ? 16'hFF00 : 16'h0000;
        send(SID, 8'h05, 16'h0812 + 16'(idx), val);
        fm[idx] = v;
        chk(rsp_valid && !rsp_exc && rsp_func == 8'h05 && rsp_echo_addr == 16'h0812 + 16'(idx)
            && rsp_echo_val == val && rsp_bytes == 0, "R4 write-bit echo",
            {rsp_echo_addr, rsp_echo_val}, {16'h0812 + 16'(idx), val});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_slave = '0; req_func = '0; req_start = '0; req_value = '0;
        fm = '{0, 0, 1, 0, 0};
        for (int i = 0; i < 8; i++) wm[i] = '0;
        repeat (3) @(negedge clk);
        chk(!rsp_valid, "R2 no response in reset", rsp_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!rsp_valid, "R2 idle after reset", rsp_valid, 0);

        // R2 reset contents
        rd_bits(16'h0812, 5, "R2");
        rd_words(16'h1000, 4, "R2");
        rd_words(16'h1004, 4, "R2");

        // R1 one-cycle response
        send(SID, 8'h02, 16'h0812, 16'd1);
        @(negedge clk);
        chk(!rsp_valid, "R1 response lasts one cycle", rsp_valid, 0);

        // R4 exhaustive flag patterns, then R3 readback
        for (int p = 0; p < 32; p++) begin
            for (int i = 0; i < 5; i++) wr_bit(i, p[i]);
            send(SID, 8'h02, 16'h0812, 16'd5);
            chk(rsp_data[63:56] == 8'(p), "R4 flag pattern readback", rsp_data[63:56], 8'(p));
        end
        for (int i = 0; i < 5; i++) wr_bit(i, (i % 2) == 0);

        // R4 bad write-bit values
        foreach (fm[i]) begin end
        send(SID, 8'h05, 16'h0813, 16'h1234);  expect_exc(8'h05, "R4 bad value 1234");
        send(SID, 8'h05, 16'h0813, 16'hFF01);  expect_exc(8'h05, "R4 bad value FF01");
        send(SID, 8'h05, 16'h0812, 16'h00FF);  expect_exc(8'h05, "R4 bad value 00FF");
        rd_bits(16'h0812, 5, "R4 unchanged after bad value");

        // R3 sweep over window starts and counts
        for (int s = 'h80E; s <= 'h818; s++)
            for (int c = 1; c <= 8; c++) rd_bits(16'(s), c, "R3");
        rd_bits(16'h0000, 8, "R3 far below");
        rd_bits(16'hFFFC, 8, "R3 wrap edge");

        // R6 word writes with echo
        for (int i = 0; i < 8; i++) begin
            logic [15:0] v = 16'hA5C3 ^ (16'(i) * 16'h1111);
            send(SID, 8'h06, 16'h1000 + 16'(i), v);
            wm[i] = v;
            chk(rsp_valid && !rsp_exc && rsp_func == 8'h06 && rsp_echo_addr == 16'h1000 + 16'(i)
                && rsp_echo_val == v && rsp_bytes == 0 && rsp_data == 0, "R6 write-word echo",
                {rsp_echo_addr, rsp_echo_val}, {16'h1000 + 16'(i), v});
        end
        send(SID, 8'h06, 16'h1008, 16'hBEEF);
        chk(rsp_valid && !rsp_exc && rsp_echo_addr == 16'h1008 && rsp_echo_val == 16'hBEEF,
            "R6 unmapped echo", {rsp_echo_addr, rsp_echo_val}, {16'h1008, 16'hBEEF});
        send(SID, 8'h06, 16'h0FFF, 16'hCAFE);
        chk(rsp_valid && !rsp_exc && rsp_echo_val == 16'hCAFE, "R6 unmapped echo low",
            rsp_echo_val, 16'hCAFE);

        // R5 sweep of word windows
        for (int s = 'hFFC; s <= 'h1009; s++)
            for (int c = 1; c <= 4; c++) rd_words(16'(s), c, "R5");

        // R8 count limits
        send(SID, 8'h03, 16'h1000, 16'd0);   expect_exc(8'h03, "R8 words count 0");
        send(SID, 8'h03, 16'h1000, 16'd5);   expect_exc(8'h03, "R8 words count 5");
        send(SID, 8'h03, 16'h1000, 16'h0104); expect_exc(8'h03, "R8 words count 0104");
        send(SID, 8'h02, 16'h0812, 16'd0);   expect_exc(8'h02, "R8 bits count 0");
        send(SID, 8'h02, 16'h0812, 16'd9);   expect_exc(8'h02, "R8 bits count 9");

        // R7 every unsupported code, with payloads that would alter state
        for (int f = 0; f < 256; f++) begin
            if (f == 2 || f == 3 || f == 5 || f == 6) continue;
            if (f % 2 == 0) send(SID, 8'(f), 16'h0812, 16'h0000);
            else            send(SID, 8'(f), 16'h1001, 16'hDEAD);
            expect_exc(8'(f), "R7 unsupported code");
        end
        rd_bits(16'h0812, 5, "R7 flags unchanged");
        rd_words(16'h1000, 4, "R7 words unchanged");
        rd_words(16'h1004, 4, "R7 words unchanged");

        // R1 every foreign slave address
        for (int s = 0; s < 256; s++) begin
            if (8'(s) == SID) continue;
            if (s % 2 == 0) send(8'(s), 8'h05, 16'h0813, fm[1] ? 16'h0000 : 16'hFF00);
            else            send(8'(s), 8'h06, 16'h1002, 16'h5A5A);
            chk(!rsp_valid, "R1 foreign address silent", rsp_valid, 0);
        end
        rd_bits(16'h0812, 5, "R1 flags unchanged");
        rd_words(16'h1000, 4, "R1 words unchanged");

        // R9 success codes carry clean function field
        send(SID, 8'h06, 16'h1007, 16'h0001);
        wm[7] = 16'h0001;
        chk(!rsp_exc && rsp_func == 8'h06 && rsp_slave == SID, "R9 success function field",
            {rsp_exc, rsp_func}, {1'b0, 8'h06});
        rd_words(16'h1006, 2, "R9");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule